// File: doc/BRIEF.md
# Shutter pulse scheduler

This block decides when a sensor's substrate clearing pulse is issued so that the photodiodes start collecting charge a programmed number of line periods before the next frame's photodiode-to-vertical-register transfer. It watches the horizontal retrace window and the line index supplied by the line sequencer. It places one logic-level enable pulse inside the retrace of the line chosen for the frame, after a guard interval. An external high-voltage driver turns that enable into the actual pulse. The exposure can only move in steps of whole retrace intervals. The frame period never changes; only the line in which the pulse sits moves.

The requested exposure, pulse width and guard are captured at the frame start strobe and held for the whole frame, so a change made mid-frame takes effect from the next frame. The pulse width and guard are raised to fixed minimum values when programmed too small. The exposure request is raised to a minimum number of lines when programmed too small. If an exposure request is clamped, or a pulse is cut short because the retrace window closed, a sticky flag reports that the requested exposure was not met.

Top module: `shutter_sched`

## Requirements
- R1: After reset, `shutter_out` and `exposure_miss` are both 0 until a frame has been started and the programmed conditions occur.
- R2: `shutter_out` is high only in clock cycles that follow a rising edge at which `hretrace` was sampled high.
- R3: The pulse starts on the rising edge that comes G edges after the first edge at which `hretrace` is high on the target line, counting that first edge, so G edges in total. G is `guard_cycles`, or MIN_GUARD if `guard_cycles` is below that minimum. `hretrace` must stay high throughout.
- R4: A pulse that is not cut short stays high for exactly W cycles. W is `pulse_cycles`, or MIN_PULSE if `pulse_cycles` is below that minimum.
- R5: The target line is TOTAL_LINES minus the effective integration length in lines. The pulse is issued in the retrace of the line whose `line_idx` equals that value.
- R6: If `integ_lines` at frame start is greater than TOTAL_LINES, no pulse is issued in that frame and the flag is not set.
- R7: If `shut_enable` is 0 at frame start, no pulse is issued in that frame, so integration spans the whole frame.
- R8: If `integ_lines` at frame start is below MIN_LINES, the effective length becomes MIN_LINES and `exposure_miss` is set. It is visible two edges after the frame start edge and stays set until reset.
- R9: If `hretrace` is sampled low while the pulse or its guard is in progress, the pulse ends at that edge and `exposure_miss` is set one edge later. A pulse that completes its full width on the last high edge of the window does not set the flag.
- R10: Changes to `shut_enable`, `integ_lines`, `pulse_cycles` or `guard_cycles` between frame start strobes have no effect on the current frame.
- R11: At most one pulse is issued between two frame start strobes, and a frame start strobe ends any pulse in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle strobe at the start of each frame; captures the settings |
| hretrace | input | 1 | High while the horizontal register clocks are idle (retrace window) |
| line_idx | input | LINE_W | Index of the current line within the frame |
| shut_enable | input | 1 | 1 enables the shutter pulse for the next frame |
| integ_lines | input | LINE_W | Requested integration length in line periods |
| pulse_cycles | input | CNT_W | Requested pulse width in clock cycles |
| guard_cycles | input | CNT_W | Requested delay from retrace start to pulse start, in clock cycles |
| shutter_out | output | 1 | Logic-level enable for the external substrate pulse driver |
| exposure_miss | output | 1 | Sticky flag: exposure clamped or pulse cut short |

## Verification
The bench aims at the line-zero target, where the frame start edge and the first retrace of the line are only two cycles apart. A scheduler that compared against stale settings would miss that retrace and give no pulse in the frame. It runs a pulse whose guard plus width exactly fills the retrace window. A design that checked the window before the width counter would wrongly raise the flag there. It also runs a pulse that overruns the window, where a missing cut-off would drive the pulse into readout. Every frame rewrites all settings in its middle, during a guard interval in one case, so a design that did not hold its settings per frame would move or drop its pulse. Requests above the frame length, below the minimum and with the shutter disabled check that no pulse, or a clamped pulse, appears. These frames also check that the flag is raised only when it should be.

// File: rtl/shs_pkg.sv
package shs_pkg;

    // Width of line indices and integration requests (up to 1023 lines).
    localparam int LINE_W = 10;
    // Width of the cycle counters for pulse width and guard.
    localparam int CNT_W  = 16;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ARMED,
        S_GUARD,
        S_PULSE,
        S_DONE
    } shs_state_e;

    // Settings captured once per frame.
    typedef struct packed {
        logic              active;
        logic [LINE_W-1:0] target;
        logic [CNT_W-1:0]  guard;
        logic [CNT_W-1:0]  width;
    } shs_cfg_t;

    function automatic logic [CNT_W-1:0] cnt_floor(
        input logic [CNT_W-1:0] value,
        input logic [CNT_W-1:0] lowest
    );
        return (value < lowest) ? lowest : value;
    endfunction

endpackage

// File: rtl/shs_cfg_latch.sv
module shs_cfg_latch
    import shs_pkg::*;
#(
    parameter int TOTAL_LINES = 496,
    parameter int MIN_LINES   = 4,
    parameter int MIN_PULSE   = 500,
    parameter int MIN_GUARD   = 50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              shut_enable,
    input  logic [LINE_W-1:0] integ_lines,
    input  logic [CNT_W-1:0]  pulse_cycles,
    input  logic [CNT_W-1:0]  guard_cycles,
    output shs_cfg_t          cfg,
    output logic              clamp_hit
);
    localparam logic [LINE_W-1:0] TOTAL_L = LINE_W'(TOTAL_LINES);
    localparam logic [LINE_W-1:0] MIN_L   = LINE_W'(MIN_LINES);
    localparam logic [CNT_W-1:0]  MIN_P   = CNT_W'(MIN_PULSE);
    localparam logic [CNT_W-1:0]  MIN_G   = CNT_W'(MIN_GUARD);

    logic              req_ok;
    logic              too_short;
    logic [LINE_W-1:0] eff_lines;
    shs_cfg_t          cfg_nxt;

    always_comb begin
        req_ok         = shut_enable && (integ_lines <= TOTAL_L);
        too_short      = integ_lines < MIN_L;
        eff_lines      = too_short ? MIN_L : integ_lines;
        cfg_nxt.active = req_ok;
        cfg_nxt.target = TOTAL_L - eff_lines;
        cfg_nxt.width  = cnt_floor(pulse_cycles, MIN_P);
        cfg_nxt.guard  = cnt_floor(guard_cycles, MIN_G);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= '0;
            clamp_hit <= 1'b0;
        end else begin
            clamp_hit <= frame_start && req_ok && too_short;
            if (frame_start) begin
                cfg <= cfg_nxt;
            end
        end
    end

endmodule

// File: rtl/shs_pulse_seq.sv
module shs_pulse_seq
    import shs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  shs_cfg_t          cfg,
    input  logic              hretrace,
    input  logic [LINE_W-1:0] line_idx,
    output logic              pulse_on,
    output logic              abort_hit
);
    shs_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             abort_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        abort_d = 1'b0;
        if (frame_start) begin
            state_d = S_ARMED;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                S_ARMED: begin
                    if (!cfg.active) begin
                        state_d = S_DONE;
                    end else if (hretrace && (line_idx == cfg.target)) begin
                        state_d = S_GUARD;
                        cnt_d   = CNT_W'(1);
                    end
                end
                S_GUARD: begin
                    if (!hretrace) begin
                        state_d = S_DONE;
                        abort_d = 1'b1;
                    end else if (cnt_q >= cfg.guard) begin
                        state_d = S_PULSE;
                        cnt_d   = CNT_W'(1);
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                S_PULSE: begin
                    if (cnt_q >= cfg.width) begin
                        state_d = S_DONE;
                    end else if (!hretrace) begin
                        state_d = S_DONE;
                        abort_d = 1'b1;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                default: begin
                    state_d = state_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_IDLE;
            cnt_q     <= '0;
            abort_hit <= 1'b0;
        end else begin
            state_q   <= state_d;
            cnt_q     <= cnt_d;
            abort_hit <= abort_d;
        end
    end

    assign pulse_on = (state_q == S_PULSE);

endmodule

// File: rtl/shs_status.sv
module shs_status #(
    parameter int N_SRC = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] events,
    output logic             sticky
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sticky <= 1'b0;
        end else if (|events) begin
            sticky <= 1'b1;
        end
    end
endmodule

// File: rtl/shutter_sched.sv
module shutter_sched
    import shs_pkg::*;
#(
    parameter int TOTAL_LINES = 496,
    parameter int MIN_LINES   = 4,
    parameter int MIN_PULSE   = 500,
    parameter int MIN_GUARD   = 50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              hretrace,
    input  logic [LINE_W-1:0] line_idx,
    input  logic              shut_enable,
    input  logic [LINE_W-1:0] integ_lines,
    input  logic [CNT_W-1:0]  pulse_cycles,
    input  logic [CNT_W-1:0]  guard_cycles,
    output logic              shutter_out,
    output logic              exposure_miss
);
    shs_cfg_t cfg;
    logic     clamp_hit;
    logic     abort_hit;

    shs_cfg_latch #(
        .TOTAL_LINES (TOTAL_LINES),
        .MIN_LINES   (MIN_LINES),
        .MIN_PULSE   (MIN_PULSE),
        .MIN_GUARD   (MIN_GUARD)
    ) u_cfg (
        .clk          (clk),
        .rst          (rst),
        .frame_start  (frame_start),
        .shut_enable  (shut_enable),
        .integ_lines  (integ_lines),
        .pulse_cycles (pulse_cycles),
        .guard_cycles (guard_cycles),
        .cfg          (cfg),
        .clamp_hit    (clamp_hit)
    );

    shs_pulse_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .cfg         (cfg),
        .hretrace    (hretrace),
        .line_idx    (line_idx),
        .pulse_on    (shutter_out),
        .abort_hit   (abort_hit)
    );

    shs_status #(.N_SRC(2)) u_status (
        .clk    (clk),
        .rst    (rst),
        .events ({abort_hit, clamp_hit}),
        .sticky (exposure_miss)
    );

endmodule

// File: rtl/shutter_sched_chk.sv
module shutter_sched_chk
    import shs_pkg::*;
#(
    parameter int TOTAL_LINES = 496
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_start,
    input logic              hretrace,
    input logic              shut_enable,
    input logic [LINE_W-1:0] integ_lines,
    input logic              shutter_out,
    input logic              exposure_miss
);
    logic       off_q;
    logic       prev_out;
    logic [1:0] rises;

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q    <= 1'b1;
            prev_out <= 1'b0;
            rises    <= '0;
        end else begin
            prev_out <= shutter_out;
            if (frame_start) begin
                off_q <= !shut_enable || (integ_lines > LINE_W'(TOTAL_LINES));
                rises <= '0;
            end else if (shutter_out && !prev_out && rises != 2'd3) begin
                rises <= rises + 2'd1;
            end
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!shutter_out && !exposure_miss)); // R1

    AST_ONLY_IN_RETRACE: assert property (@(posedge clk) disable iff (rst)
        shutter_out |-> $past(hretrace)); // R2

    AST_DROP_AT_RETRACE_END: assert property (@(posedge clk) disable iff (rst)
        (shutter_out && !hretrace) |=> !shutter_out); // R9

    AST_NO_PULSE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        off_q |-> !shutter_out); // R7

    AST_MISS_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(exposure_miss) |-> exposure_miss); // R8

    AST_ONE_PULSE_PER_FRAME: assert property (@(posedge clk) disable iff (rst)
        rises <= 2'd1); // R11

endmodule

bind shutter_sched shutter_sched_chk #(.TOTAL_LINES(TOTAL_LINES)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .frame_start   (frame_start),
    .hretrace      (hretrace),
    .shut_enable   (shut_enable),
    .integ_lines   (integ_lines),
    .shutter_out   (shutter_out),
    .exposure_miss (exposure_miss)
);

// File: tb/shutter_sched_bench.sv
module shutter_sched_bench;
    import shs_pkg::*;

    localparam int TOTAL    = 12;
    localparam int MINL     = 2;
    localparam int MINP     = 4;
    localparam int MING     = 2;
    localparam int LINE_CYC = 40;
    localparam int RET      = 20;
    localparam int FRAME    = TOTAL * LINE_CYC;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              frame_start = 1'b0;
    logic              hretrace = 1'b0;
    logic [LINE_W-1:0] line_idx = '0;
    logic              shut_enable = 1'b0;
    logic [LINE_W-1:0] integ_lines = '0;
    logic [CNT_W-1:0]  pulse_cycles = '0;
    logic [CNT_W-1:0]  guard_cycles = '0;
    logic              shutter_out;
    logic              exposure_miss;

    always #10 clk = ~clk;

    shutter_sched #(
        .TOTAL_LINES (TOTAL),
        .MIN_LINES   (MINL),
        .MIN_PULSE   (MINP),
        .MIN_GUARD   (MING)
    ) u_shutter_sched (
        .clk           (clk),
        .rst           (rst),
        .frame_start   (frame_start),
        .hretrace      (hretrace),
        .line_idx      (line_idx),
        .shut_enable   (shut_enable),
        .integ_lines   (integ_lines),
        .pulse_cycles  (pulse_cycles),
        .guard_cycles  (guard_cycles),
        .shutter_out   (shutter_out),
        .exposure_miss (exposure_miss)
    );

    // Frame scenarios: enable, integration lines, width, guard, tag.
    int    sc_en [9] = '{1, 1, 1, 0, 1, 1, 1, 1, 1};
    int    sc_int[9] = '{5, 12, 13, 5, 4, 6, 3, 0, 2};
    int    sc_pw [9] = '{6, 8, 6, 6, 1, 15, 15, 4, 5};
    int    sc_gd [9] = '{3, 2, 2, 2, 0, 5, 8, 2, 3};
    string sc_tag[9] = '{"R5", "R5 (line zero)", "R6", "R7", "R3 R4",
                         "R9 (exact fit)", "R9 (overrun)", "R8 (clamp)", "R8 (sticky)"};

    int    checks = 0;
    int    errors = 0;
    int    ws, we, ab_edge, cl_edge;
    bit    m_out, m_miss, prev_out;
    int    hi_cnt, rises;
    string cur_tag;

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int imin(int a, int b);
        return (a < b) ? a : b;
    endfunction

    task automatic model_clear();
        ws = -1; we = -2; ab_edge = -100; cl_edge = -100;
        m_out = 0; m_miss = 0; prev_out = 0; hi_cnt = 0; rises = 0;
        cur_tag = "R1";
    endtask

    task automatic do_reset();
        rst = 1'b1;
        frame_start = 1'b0;
        hretrace = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (shutter_out !== 1'b0 || exposure_miss !== 1'b0) begin
            errors++;
            $display("FAIL R1: out=%0b miss=%0b expected 0 0", shutter_out, exposure_miss);
        end
        rst = 1'b0;
        model_clear();
    endtask

    // Model reaction to the frame start edge F using the settings driven for it.
    task automatic model_frame(int f_edge);
        int eff, g, p, k;
        ws = -1; we = -2; ab_edge = -100; cl_edge = -100;
        if (shut_enable && int'(integ_lines) <= TOTAL) begin
            eff = imax(int'(integ_lines), MINL);
            if (int'(integ_lines) < MINL) cl_edge = f_edge;
            g = imax(int'(guard_cycles), MING);
            p = imax(int'(pulse_cycles), MINP);
            k = f_edge + (TOTAL - eff) * LINE_CYC + 2;
            if (g < RET) begin
                ws = k + g;
                we = imin(k + g + p - 1, k + RET - 1);
            end
            if (g + p > RET) ab_edge = k + RET;
        end
    endtask

    task automatic run_phase(int first, int nfr);
        for (int n = 0; n <= nfr * FRAME; n++) begin
            @(negedge clk);
            if (n > 0) begin
                checks++;
                if (shutter_out !== m_out) begin
                    errors++;
                    $display("FAIL R2 R10 %s: shutter_out=%0b expected %0b after edge %0d",
                             cur_tag, shutter_out, m_out, n - 1);
                end
                checks++;
                if (exposure_miss !== m_miss) begin
                    errors++;
                    $display("FAIL %s: exposure_miss=%0b expected %0b after edge %0d",
                             cur_tag, exposure_miss, m_miss, n - 1);
                end
                if (shutter_out && !prev_out) rises++;
                if (shutter_out) hi_cnt++;
                prev_out = shutter_out;
            end
            if (n > 0 && n % FRAME == 0) begin
                checks++;
                if (hi_cnt != imax(we - ws + 1, 0) || rises != ((ws >= 0) ? 1 : 0)) begin
                    errors++;
                    $display("FAIL R4 R11 %s: high=%0d rises=%0d expected %0d %0d",
                             cur_tag, hi_cnt, rises, imax(we - ws + 1, 0), (ws >= 0) ? 1 : 0);
                end
                hi_cnt = 0;
                rises = 0;
            end
            if (n < nfr * FRAME) begin
                frame_start = (n % FRAME == 0);
                line_idx    = LINE_W'((n % FRAME) / LINE_CYC);
                hretrace    = ((n % LINE_CYC) >= 2) && ((n % LINE_CYC) < 2 + RET);
                if (n % FRAME == 0) begin
                    shut_enable  = (sc_en[first + n / FRAME] != 0);
                    integ_lines  = LINE_W'(sc_int[first + n / FRAME]);
                    pulse_cycles = CNT_W'(sc_pw[first + n / FRAME]);
                    guard_cycles = CNT_W'(sc_gd[first + n / FRAME]);
                    cur_tag      = sc_tag[first + n / FRAME];
                    model_frame(n);
                end else if (n % FRAME == FRAME / 2 + 3) begin
                    // R10: scramble every setting mid-frame
                    shut_enable  = ~shut_enable;
                    integ_lines  = LINE_W'(1);
                    pulse_cycles = CNT_W'(30);
                    guard_cycles = CNT_W'(0);
                end
            end else begin
                frame_start = 1'b0;
                hretrace    = 1'b0;
            end
            m_out  = (ws >= 0) && (n >= ws) && (n <= we);
            m_miss = m_miss || (n == cl_edge + 1) || (n == ab_edge + 1);
        end
    endtask

    initial begin
        fork
            begin
                do_reset();
                run_phase(0, 7);
                do_reset();
                run_phase(7, 2);
            end
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: run did not complete, expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule